// File: doc/BRIEF.md
# SPI Flash Command Frame Decoder

This block is the slave-side front end of a serial flash device. It oversamples the SPI pins with the chip's own clock and accepts traffic in either SPI mode 0 or mode 3. While chip select is low, bits are taken on each rising serial-clock edge, most significant bit first. The first byte of every frame is the opcode. A lookup table turns the opcode into a command code and gives the number of address bytes, dummy bytes and payload bytes, and says whether a confirmation byte is needed.

Once the header is complete, the decoder pulses a command-valid strobe with the code and the 24-bit address. Each later payload byte is passed on through a data strobe, up to the per-command limit. Commands that change device state (erase, program, write status, write enable or disable, power modes, reset) also produce a commit pulse when chip select rises. The pulse is only given if the frame ended on a byte boundary. An unknown opcode, or a bad reset confirmation, raises an illegal flag, and the rest of that frame is ignored.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid`, `data_strobe`, `commit` and `illegal` are 0 and `cmd_code` and `cmd_addr` are 0. Bits are taken on rising `spi_sclk` edges while `spi_cs_n` is low, MSB first, with the clock idling either low (mode 0) or high (mode 3).
- R2: Opcodes 81h (code 1), 20h (code 2), 52h and D8h (both code 3) take three address bytes, most significant first. `cmd_valid` pulses once after the third address byte with that code and address, and a byte-aligned deselect gives `commit`.
- R3: Opcodes 60h and C7h give code 4 with no address bytes. `cmd_valid` pulses right after the opcode, and `commit` follows on deselect.
- R4: Opcode 02h (code 5) takes three address bytes. Each following byte pulses `data_strobe` with `data_byte`, for at most 256 bytes, and later bytes are dropped. `commit` requires at least one payload byte. Opcode 9Bh (code 8) behaves the same with a limit of 64.
- R5: Opcode 05h (code 10) takes no address. Opcodes 01h (code 11) and 31h (code 12) take no address and accept exactly one payload byte. Further bytes give no strobe. `commit` requires that byte.
- R6: Opcode F0h (code 13) needs a second byte of D0h. `cmd_valid` and, on deselect, `commit` follow only that byte. Any other second byte raises `illegal`, and the frame gives no `cmd_valid` and no `commit`.
- R7: Opcodes 06h (code 6), 04h (code 7), B9h (code 16), ABh (code 17) and 79h (code 18) commit on deselect. Opcodes 9Fh (code 14) and 15h (code 15) do not.
- R8: Opcode 77h (code 9) takes three address bytes and two dummy bytes. `cmd_valid` pulses only after the second dummy byte.
- R9: Deselecting before the address, dummy or confirmation bytes are complete gives neither `cmd_valid` nor `commit`.
- R10: A deselect that falls in the middle of a byte gives no `commit`, even after a complete header.
- R11: Any opcode not listed here raises `illegal` from the end of the opcode byte until deselect. No strobe of any kind comes from that frame.
- R12: The read commands (05h, 77h, 9Fh, 15h) never commit and never pulse `data_strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock pin |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| cmd_valid | output | 1 | One-cycle pulse when a command header is complete |
| cmd_code | output | 5 | Decoded command code, held until the next header |
| cmd_addr | output | 24 | Address collected for the command |
| data_strobe | output | 1 | One-cycle pulse per accepted payload byte |
| data_byte | output | 8 | Payload byte qualified by `data_strobe` |
| commit | output | 1 | One-cycle pulse at a valid, byte-aligned end of frame |
| illegal | output | 1 | High while the rest of a rejected frame is ignored |

## Verification
The hardest cases to reach are at the edges of each frame: a deselect that lands a few bits into a byte, or one that lands one byte short of the header. Payload overflow past the 256-byte program limit is also hard to reach. The bench reaches these with a bit-granular driver that can stop after any number of bits, and with a 258-byte program frame. It also sweeps all 256 opcodes as one-byte frames, alternating the two clock modes. For each opcode it compares `cmd_valid`, `commit`, `illegal` and the code against a table kept in the bench.

// File: rtl/spi_cmd_pkg.sv
// Shared types for the SPI command decoder: command codes, per-opcode
// table entry, and width constants. Assumes 8-bit bytes and 24-bit addresses.
package spi_cmd_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 24;
    localparam int DCNT_W   = 9;
    localparam logic [BYTE_W-1:0] RESET_CONFIRM = 8'hD0;

    typedef enum logic [4:0] {
        CMD_NONE        = 5'd0,
        CMD_PAGE_ERASE  = 5'd1,
        CMD_BLK4_ERASE  = 5'd2,
        CMD_BLK32_ERASE = 5'd3,
        CMD_CHIP_ERASE  = 5'd4,
        CMD_PROGRAM     = 5'd5,
        CMD_WR_ENABLE   = 5'd6,
        CMD_WR_DISABLE  = 5'd7,
        CMD_SEC_PROGRAM = 5'd8,
        CMD_SEC_READ    = 5'd9,
        CMD_RD_STATUS   = 5'd10,
        CMD_WR_STAT1    = 5'd11,
        CMD_WR_STAT2    = 5'd12,
        CMD_RESET       = 5'd13,
        CMD_READ_ID     = 5'd14,
        CMD_READ_ID_OLD = 5'd15,
        CMD_SLEEP       = 5'd16,
        CMD_WAKE        = 5'd17,
        CMD_DEEP_SLEEP  = 5'd18
    } cmd_e;

    typedef struct packed {
        logic              known;
        cmd_e              code;
        logic [1:0]        addr_bytes;
        logic [1:0]        dummy_bytes;
        logic              confirm;
        logic              commits;
        logic              needs_data;
        logic [DCNT_W-1:0] max_data;
    } cmd_info_t;
endpackage

// File: rtl/spi_byte_rx.sv
// Oversampling SPI receiver. Synchronises the three pins into clk,
// detects rising serial-clock edges while selected and assembles bytes
// MSB first. Assumes clk runs at least four times the serial clock.
module spi_byte_rx
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              selected,
    output logic              cs_rise,
    output logic              on_boundary
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES:0]   sclk_sh;
    logic [SYNC_STAGES:0]   cs_sh;
    logic [SYNC_STAGES-1:0] mosi_sh;
    logic [BIT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      shreg;
    logic                   sclk_rise;
    logic                   mosi_now;

    // Synchroniser chains; one extra stage on clock and select for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sh <= '0;
            cs_sh   <= '1;
            mosi_sh <= '0;
        end else begin
            sclk_sh <= {sclk_sh[SYNC_STAGES-1:0], sclk};
            cs_sh   <= {cs_sh[SYNC_STAGES-1:0], cs_n};
            mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
        end
    end

    assign selected    = ~cs_sh[SYNC_STAGES-1];
    assign cs_rise     = cs_sh[SYNC_STAGES-1] & ~cs_sh[SYNC_STAGES];
    assign sclk_rise   = sclk_sh[SYNC_STAGES-1] & ~sclk_sh[SYNC_STAGES];
    assign mosi_now    = mosi_sh[SYNC_STAGES-1];
    assign on_boundary = (bit_cnt == '0);

    // Shift bits in on rising serial clock; emit a byte every BYTE_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!selected) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg   <= {shreg[BYTE_W-2:0], mosi_now};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= {shreg[BYTE_W-2:0], mosi_now};
                end
            end
        end
    end

    // R1: a deselected receiver always restarts at bit zero
    p_bitcnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |=> on_boundary);
endmodule

// File: rtl/spi_cmd_table.sv
// Opcode lookup table. Pure combinational; maps an opcode to its command
// code and frame shape. Unknown opcodes return known = 0.
module spi_cmd_table
    import spi_cmd_pkg::*;
#(
    parameter int PROG_MAX = 256,
    parameter int SEC_MAX  = 64
) (
    input  logic [BYTE_W-1:0] opcode,
    output cmd_info_t         info
);
    // Build one entry from its fields.
    function automatic cmd_info_t mk(cmd_e c, int a, int d, logic cf,
                                     logic cm, logic nd, int mx);
        cmd_info_t e;
        e.known       = 1'b1;
        e.code        = c;
        e.addr_bytes  = 2'(a);
        e.dummy_bytes = 2'(d);
        e.confirm     = cf;
        e.commits     = cm;
        e.needs_data  = nd;
        e.max_data    = DCNT_W'(mx);
        return e;
    endfunction

    // Decode the opcode.
    always_comb begin
        info = '0;
        case (opcode)
            8'h81: info = mk(CMD_PAGE_ERASE,  3, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h20: info = mk(CMD_BLK4_ERASE,  3, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h52,
            8'hD8: info = mk(CMD_BLK32_ERASE, 3, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h60,
            8'hC7: info = mk(CMD_CHIP_ERASE,  0, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h02: info = mk(CMD_PROGRAM,     3, 0, 1'b0, 1'b1, 1'b1, PROG_MAX);
            8'h06: info = mk(CMD_WR_ENABLE,   0, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h04: info = mk(CMD_WR_DISABLE,  0, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h9B: info = mk(CMD_SEC_PROGRAM, 3, 0, 1'b0, 1'b1, 1'b1, SEC_MAX);
            8'h77: info = mk(CMD_SEC_READ,    3, 2, 1'b0, 1'b0, 1'b0, 0);
            8'h05: info = mk(CMD_RD_STATUS,   0, 0, 1'b0, 1'b0, 1'b0, 0);
            8'h01: info = mk(CMD_WR_STAT1,    0, 0, 1'b0, 1'b1, 1'b1, 1);
            8'h31: info = mk(CMD_WR_STAT2,    0, 0, 1'b0, 1'b1, 1'b1, 1);
            8'hF0: info = mk(CMD_RESET,       0, 0, 1'b1, 1'b1, 1'b0, 0);
            8'h9F: info = mk(CMD_READ_ID,     0, 0, 1'b0, 1'b0, 1'b0, 0);
            8'h15: info = mk(CMD_READ_ID_OLD, 0, 0, 1'b0, 1'b0, 1'b0, 0);
            8'hB9: info = mk(CMD_SLEEP,       0, 0, 1'b0, 1'b1, 1'b0, 0);
            8'hAB: info = mk(CMD_WAKE,        0, 0, 1'b0, 1'b1, 1'b0, 0);
            8'h79: info = mk(CMD_DEEP_SLEEP,  0, 0, 1'b0, 1'b1, 1'b0, 0);
            default: info = '0;
        endcase
    end
endmodule

// File: rtl/spi_frame_fsm.sv
// Frame sequencer. Walks opcode, address, dummy, confirmation and payload
// phases from the table entry, issues command/data/commit strobes, and
// ignores the rest of a rejected frame. Assumes one byte_valid at most
// every eight cycles.
module spi_frame_fsm
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              selected,
    input  logic              cs_rise,
    input  logic              on_boundary,
    input  cmd_info_t         lut,
    output logic              cmd_valid,
    output cmd_e              cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              data_strobe,
    output logic [BYTE_W-1:0] data_byte,
    output logic              commit,
    output logic              illegal
);
    typedef enum logic [2:0] {S_OPCODE, S_ADDR, S_DUMMY, S_CONFIRM, S_DATA, S_IGNORE} state_e;

    state_e            state, state_n;
    cmd_info_t         info_q, info_n;
    logic [1:0]        cnt, cnt_n;
    logic [ADDR_W-1:0] addr_n;
    logic [DCNT_W-1:0] dcnt, dcnt_n;
    cmd_e              code_n;
    logic              valid_n, strobe_n, commit_n, illegal_n;

    // Phase that follows the address bytes for a given entry.
    function automatic state_e after_addr(cmd_info_t i);
        if (i.confirm)                return S_CONFIRM;
        else if (i.dummy_bytes != '0) return S_DUMMY;
        else                          return S_DATA;
    endfunction

    // Next-state and strobe logic for one frame.
    always_comb begin
        state_n   = state;
        info_n    = info_q;
        cnt_n     = cnt;
        addr_n    = cmd_addr;
        dcnt_n    = dcnt;
        code_n    = cmd_code;
        valid_n   = 1'b0;
        strobe_n  = 1'b0;
        commit_n  = 1'b0;
        illegal_n = illegal;
        if (cs_rise) begin
            commit_n  = (state == S_DATA) && on_boundary && info_q.commits &&
                        (!info_q.needs_data || dcnt != '0);
            state_n   = S_OPCODE;
            illegal_n = 1'b0;
        end else if (!selected) begin
            state_n   = S_OPCODE;
            illegal_n = 1'b0;
        end else if (byte_valid) begin
            case (state)
                S_OPCODE: begin
                    if (!lut.known) begin
                        state_n   = S_IGNORE;
                        illegal_n = 1'b1;
                    end else begin
                        info_n  = lut;
                        addr_n  = '0;
                        dcnt_n  = '0;
                        state_n = (lut.addr_bytes != '0) ? S_ADDR : after_addr(lut);
                    end
                end
                S_ADDR: begin
                    addr_n = {cmd_addr[ADDR_W-BYTE_W-1:0], byte_data};
                    if (cnt == '0) state_n = after_addr(info_q);
                    else           cnt_n   = cnt - 2'd1;
                end
                S_DUMMY: begin
                    if (cnt == '0) state_n = S_DATA;
                    else           cnt_n   = cnt - 2'd1;
                end
                S_CONFIRM: begin
                    if (byte_data == RESET_CONFIRM) begin
                        state_n = S_DATA;
                    end else begin
                        state_n   = S_IGNORE;
                        illegal_n = 1'b1;
                    end
                end
                S_DATA: begin
                    if (info_q.needs_data && dcnt < info_q.max_data) begin
                        strobe_n = 1'b1;
                        dcnt_n   = dcnt + DCNT_W'(1);
                    end
                end
                default: ;
            endcase
            if (state_n == S_ADDR && state != S_ADDR)
                cnt_n = info_n.addr_bytes - 2'd1;
            if (state_n == S_DUMMY && state != S_DUMMY)
                cnt_n = info_n.dummy_bytes - 2'd1;
            if (state_n == S_DATA && state != S_DATA) begin
                valid_n = 1'b1;
                code_n  = info_n.code;
            end
        end
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_OPCODE;
            info_q      <= '0;
            cnt         <= '0;
            cmd_addr    <= '0;
            dcnt        <= '0;
            cmd_code    <= CMD_NONE;
            cmd_valid   <= 1'b0;
            data_strobe <= 1'b0;
            data_byte   <= '0;
            commit      <= 1'b0;
            illegal     <= 1'b0;
        end else begin
            state       <= state_n;
            info_q      <= info_n;
            cnt         <= cnt_n;
            cmd_addr    <= addr_n;
            dcnt        <= dcnt_n;
            cmd_code    <= code_n;
            cmd_valid   <= valid_n;
            data_strobe <= strobe_n;
            if (strobe_n) data_byte <= byte_data;
            commit      <= commit_n;
            illegal     <= illegal_n;
        end
    end

    // R11: a rejected frame emits nothing
    p_quiet_when_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !data_strobe && !cmd_valid && !commit);
    // R4: payload never exceeds the command limit
    p_payload_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe |-> dcnt <= info_q.max_data && dcnt != '0);
    // R10: commit only appears right after the select edge
    p_commit_at_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !selected);
    // R2: the address is frozen during the payload phase
    p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && $past(state) == S_DATA) |-> $stable(cmd_addr));
    // R12: read commands never commit
    p_read_no_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !(cmd_code inside {CMD_RD_STATUS, CMD_SEC_READ, CMD_READ_ID, CMD_READ_ID_OLD}));
endmodule

// File: rtl/spi_cmd_decoder.sv
// Top of the SPI flash command decoder: receiver, opcode table and frame
// sequencer. Assumes clk is at least four times the serial clock rate.
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PROG_MAX    = 256,
    parameter int SEC_MAX     = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        cmd_valid,
    output logic [4:0]  cmd_code,
    output logic [23:0] cmd_addr,
    output logic        data_strobe,
    output logic [7:0]  data_byte,
    output logic        commit,
    output logic        illegal
);
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;
    logic              selected;
    logic              cs_rise;
    logic              on_boundary;
    cmd_info_t         lut;
    cmd_e              code_e;

    spi_byte_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .byte_valid(byte_valid), .byte_data(byte_data), .selected(selected),
        .cs_rise(cs_rise), .on_boundary(on_boundary)
    );

    spi_cmd_table #(.PROG_MAX(PROG_MAX), .SEC_MAX(SEC_MAX)) u_table (
        .opcode(byte_data), .info(lut)
    );

    spi_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
        .selected(selected), .cs_rise(cs_rise), .on_boundary(on_boundary), .lut(lut),
        .cmd_valid(cmd_valid), .cmd_code(code_e), .cmd_addr(cmd_addr),
        .data_strobe(data_strobe), .data_byte(data_byte), .commit(commit),
        .illegal(illegal)
    );

    assign cmd_code = code_e;
endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        cmd_valid, data_strobe, commit, illegal;
    logic [4:0]  cmd_code;
    logic [23:0] cmd_addr;
    logic [7:0]  data_byte;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_commit = 0, n_strobe = 0, n_ill = 0;
    int last_code = 0, last_addr = 0, commit_code = 0;
    logic [7:0] dlog [0:1023];
    int b_valid, b_commit, b_strobe, b_ill;
    bit mode3 = 1'b0;

    always #5 clk = ~clk;

    spi_cmd_decoder u_spi_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .data_strobe(data_strobe), .data_byte(data_byte), .commit(commit),
        .illegal(illegal)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (cmd_valid) begin n_valid++; last_code = cmd_code; last_addr = cmd_addr; end
        if (commit) begin n_commit++; commit_code = cmd_code; end
        if (data_strobe) begin dlog[n_strobe % 1024] = data_byte; n_strobe++; end
        if (illegal) n_ill++;
    end

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_begin(bit m3);
        mode3 = m3;
        sclk  = m3;
        wclk(HALF);
        b_valid = n_valid; b_commit = n_commit; b_strobe = n_strobe; b_ill = n_ill;
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic spi_bits(logic [7:0] v, int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sclk = 1'b0; mosi = v[i]; wclk(HALF);
            sclk = 1'b1; wclk(HALF);
        end
    endtask

    task automatic spi_byte(logic [7:0] v);
        spi_bits(v, 8);
    endtask

    task automatic spi_end();
        if (!mode3) begin sclk = 1'b0; wclk(HALF); end
        cs_n = 1'b1;
        wclk(10);
    endtask

    task automatic send_addr(int a);
        spi_byte(a[23:16]); spi_byte(a[15:8]); spi_byte(a[7:0]);
    endtask

    // Bench command table: code, address bytes, confirm, commit without data.
    function automatic void ref_op(input int op, output int code, output int na,
                                   output bit cf, output bit cm);
        na = 0; cf = 0; cm = 1;
        case (op)
            'h81: begin code = 1; na = 3; end
            'h20: begin code = 2; na = 3; end
            'h52, 'hD8: begin code = 3; na = 3; end
            'h60, 'hC7: code = 4;
            'h02: begin code = 5; na = 3; cm = 0; end
            'h06: code = 6;
            'h04: code = 7;
            'h9B: begin code = 8; na = 3; cm = 0; end
            'h77: begin code = 9; na = 3; cm = 0; end
            'h05: begin code = 10; cm = 0; end
            'h01: begin code = 11; cm = 0; end
            'h31: begin code = 12; cm = 0; end
            'hF0: begin code = 13; cf = 1; end
            'h9F: begin code = 14; cm = 0; end
            'h15: begin code = 15; cm = 0; end
            'hB9: code = 16;
            'hAB: code = 17;
            'h79: code = 18;
            default: code = -1;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin : main
        int code, na, dv, dc;
        bit cf, cm;
        wclk(4);
        // R1: reset state
        check(cmd_valid == 0 && data_strobe == 0 && commit == 0 && illegal == 0,
              "R1 reset strobes", int'(cmd_valid | data_strobe | commit | illegal), 0);
        check(cmd_code == 0 && cmd_addr == 0, "R1 reset code/addr", int'(cmd_code), 0);
        rst_n = 1'b1;
        wclk(4);

        // R1 R3 R7 R11 R12: sweep all opcodes as single-byte frames, both modes
        for (int op = 0; op < 256; op++) begin
            ref_op(op, code, na, cf, cm);
            spi_begin(op[0]);
            spi_byte(op[7:0]);
            spi_end();
            dv = (code >= 0 && na == 0 && !cf) ? 1 : 0;
            dc = (dv == 1 && cm) ? 1 : 0;
            check(n_valid - b_valid == dv, $sformatf("R7 op %02h valid", op), n_valid - b_valid, dv);
            check(n_commit - b_commit == dc, $sformatf("R12 op %02h commit", op), n_commit - b_commit, dc);
            check((n_ill - b_ill > 0) == (code < 0), $sformatf("R11 op %02h illegal", op),
                  int'(n_ill - b_ill > 0), int'(code < 0));
            if (dv == 1) check(last_code == code, $sformatf("R3 op %02h code", op), last_code, code);
        end

        // R2: erase with address, mode 3
        spi_begin(1); spi_byte(8'h81); send_addr('h123456); spi_end();
        check(n_valid - b_valid == 1 && last_code == 1, "R2 page erase valid", last_code, 1);
        check(last_addr == 'h123456, "R2 page erase addr", last_addr, 'h123456);
        check(n_commit - b_commit == 1 && commit_code == 1, "R2 page erase commit", n_commit - b_commit, 1);
        spi_begin(0); spi_byte(8'hD8); send_addr('hABCDEF); spi_end();
        check(last_code == 3 && last_addr == 'hABCDEF, "R2 block32 D8", last_addr, 'hABCDEF);
        spi_begin(0); spi_byte(8'h20); send_addr('h000FFF); spi_end();
        check(last_code == 2 && n_commit - b_commit == 1, "R2 block4", last_code, 2);

        // R4: program three bytes
        spi_begin(0); spi_byte(8'h02); send_addr('h00A5A5);
        spi_byte(8'h11); spi_byte(8'h22); spi_byte(8'h33); spi_end();
        check(n_strobe - b_strobe == 3, "R4 program strobes", n_strobe - b_strobe, 3);
        check(dlog[b_strobe % 1024] == 8'h11 && dlog[(b_strobe + 2) % 1024] == 8'h33,
              "R4 program data", int'(dlog[b_strobe % 1024]), 'h11);
        check(n_commit - b_commit == 1 && commit_code == 5, "R4 program commit", commit_code, 5);
        // R4: 258 bytes, cap at 256
        spi_begin(1); spi_byte(8'h02); send_addr('h000100);
        for (int i = 0; i < 258; i++) spi_byte(8'(i ^ 8'h5A));
        spi_end();
        check(n_strobe - b_strobe == 256, "R4 program cap", n_strobe - b_strobe, 256);
        check(dlog[(b_strobe + 255) % 1024] == 8'(255 ^ 8'h5A), "R4 last byte",
              int'(dlog[(b_strobe + 255) % 1024]), 255 ^ 'h5A);
        // R4: no payload -> no commit
        spi_begin(0); spi_byte(8'h02); send_addr('h000001); spi_end();
        check(n_valid - b_valid == 1 && n_commit - b_commit == 0, "R4 empty program", n_commit - b_commit, 0);
        // R4: secure program cap 64
        spi_begin(0); spi_byte(8'h9B); send_addr('h000000);
        for (int i = 0; i < 66; i++) spi_byte(8'(i));
        spi_end();
        check(n_strobe - b_strobe == 64 && n_commit - b_commit == 1, "R4 secure cap", n_strobe - b_strobe, 64);

        // R10: program with deselect mid-byte
        spi_begin(0); spi_byte(8'h02); send_addr('h000010); spi_byte(8'h77); spi_bits(8'hFF, 3); spi_end();
        check(n_strobe - b_strobe == 1 && n_commit - b_commit == 0, "R10 partial byte", n_commit - b_commit, 0);
        // R10: chip erase plus stray bits
        spi_begin(1); spi_byte(8'hC7); spi_bits(8'h00, 5); spi_end();
        check(n_valid - b_valid == 1 && n_commit - b_commit == 0, "R10 chip erase partial", n_commit - b_commit, 0);

        // R9: abort inside address
        spi_begin(0); spi_byte(8'h81); spi_byte(8'h01); spi_byte(8'h02); spi_end();
        check(n_valid - b_valid == 0 && n_commit - b_commit == 0, "R9 addr abort", n_valid - b_valid, 0);

        // R8: dummy bytes
        spi_begin(0); spi_byte(8'h77); send_addr('h00003F); spi_byte(8'h00); spi_end();
        check(n_valid - b_valid == 0, "R8 one dummy short", n_valid - b_valid, 0);
        spi_begin(1); spi_byte(8'h77); send_addr('h00003F); spi_byte(8'h00); spi_byte(8'h00);
        spi_byte(8'h99); spi_end();
        check(n_valid - b_valid == 1 && last_code == 9 && last_addr == 'h3F, "R8 secure read", last_addr, 'h3F);
        check(n_commit - b_commit == 0 && n_strobe - b_strobe == 0, "R12 secure read quiet", n_strobe - b_strobe, 0);

        // R6: reset confirmation
        spi_begin(0); spi_byte(8'hF0); spi_byte(8'hD0); spi_end();
        check(n_valid - b_valid == 1 && last_code == 13 && n_commit - b_commit == 1, "R6 reset ok", commit_code, 13);
        spi_begin(0); spi_byte(8'hF0); spi_byte(8'h55); spi_byte(8'hD0); spi_end();
        check(n_ill - b_ill > 0 && n_valid - b_valid == 0 && n_commit - b_commit == 0,
              "R6 bad confirm", n_commit - b_commit, 0);

        // R5: write status takes one byte
        spi_begin(0); spi_byte(8'h31); spi_byte(8'hC3); spi_byte(8'h3C); spi_end();
        check(n_strobe - b_strobe == 1 && dlog[b_strobe % 1024] == 8'hC3, "R5 status2 one byte",
              n_strobe - b_strobe, 1);
        check(n_commit - b_commit == 1 && commit_code == 12, "R5 status2 commit", commit_code, 12);
        spi_begin(1); spi_byte(8'h05); spi_byte(8'h12); spi_byte(8'h34); spi_end();
        check(n_strobe - b_strobe == 0 && n_commit - b_commit == 0, "R5 read status quiet", n_strobe - b_strobe, 0);

        // R11: unknown opcode then program-like payload
        spi_begin(0); spi_byte(8'hFF); spi_byte(8'h02); send_addr('h000000); spi_byte(8'h01); spi_end();
        check(n_ill - b_ill > 0 && n_strobe - b_strobe == 0 && n_valid - b_valid == 0 && n_commit - b_commit == 0,
              "R11 unknown ignored", n_strobe - b_strobe, 0);
        check(illegal == 0, "R11 flag clears on deselect", int'(illegal), 0);

        summary();
        $finish;
    end
endmodule